// File: doc/BRIEF.md
# Completed-Descriptor Done-Queue Linker

The linker keeps a last-in-first-out chain of finished transfer descriptors in system memory. A completion engine reports each finished descriptor by its address on a valid/ready stream. For each accepted completion, the linker issues one memory write. That write stores the current chain head into the next-pointer word of the finished descriptor, which sits eight bytes past the descriptor base. Only after the write is acknowledged does the finished descriptor become the new head. The chain therefore never points at a descriptor whose link word is not yet in memory.

A writeback command flushes the chain. The linker writes the head value to a fixed mailbox address in a shared communication area. When that write is acknowledged, the head returns to zero and a writeback-done status bit is raised. The status bit stays raised until software writes a one to clear it. Software sees the head through a read-only output. Only the linker itself changes it.

Back-pressure rules: a completion transfers on a clock edge where `cmp_valid` and `cmp_ready` are both high. `cmp_ready` is low while any memory write is outstanding and while a writeback is waiting to start. The producer must then hold `cmp_valid` and `cmp_addr` steady. The memory write is a request/acknowledge pair: `mem_req` stays high with steady address and data until a cycle in which `mem_ack` is high. At most one write is outstanding at a time.

Top module: `done_queue_linker`

## Requirements
- R1: After reset the head is zero, the status bit is clear, no memory write is requested and `cmp_ready` is high.
- R2: Head bits 3:0 always read zero. Bits 3:0 of a completion address are ignored, both for the new head and for the link-write address.
- R3: An accepted completion at aligned address A produces one write request with `mem_addr` = A + 8 and `mem_wdata` = the head at acceptance. Both stay steady while `mem_req` is high and unacknowledged.
- R4: The head becomes A on the edge where the link write is acknowledged (visible the following cycle), and not earlier.
- R5: `cmp_ready` is low while a write is outstanding or a writeback is pending. A completion offered then is held by the producer and accepted later, never dropped.
- R6: A writeback command produces a write of the head to `WB_ADDR`. On its acknowledge the head becomes zero and the status bit sets.
- R7: A writeback command arriving during a link write starts only after that link write is acknowledged. A pending writeback is served before any waiting completion.
- R8: The status bit remains set until `irq_clr` is high at a clock edge. If set and clear coincide, it stays set.
- R9: The head changes only on the acknowledge of a link write or of a writeback write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Completion address offered |
| cmp_ready | output | 1 | Linker can accept a completion |
| cmp_addr | input | ADDR_W | Address of the finished descriptor |
| wb_cmd | input | 1 | Pulse: flush the head to the mailbox |
| mem_req | output | 1 | Memory write requested |
| mem_ack | input | 1 | Memory write accepted this cycle |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | ADDR_W | Write data |
| head | output | ADDR_W | Read-only view of the chain head |
| irq_wb_done | output | 1 | Writeback-done status bit |
| irq_clr | input | 1 | Software write of one to the status bit |

## Verification
The chain is built first with an acknowledge in the same cycle as the request, which exposes the two-cycle accept/link rhythm and a head that updates too early. It is then built with a delayed acknowledge and a continuously offered completion, which separates correct stalling from dropped or duplicated completions. Writebacks are issued while idle, during a link write, and together with a waiting completion; the logged order of memory writes distinguishes correct deferral and priority from a writeback that overtakes or loses the link. Finally, a status clear is held across the writeback acknowledge, which shows whether set or clear wins.

// File: rtl/dql_pkg.sv
package dql_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LINK = 2'd1,
    ST_WB   = 2'd2
  } dql_state_e;
endpackage

// File: rtl/dql_ctrl.sv
module dql_ctrl
  import dql_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_valid,
  input  logic wb_cmd,
  input  logic mem_ack,
  output logic cmp_ready,
  output logic mem_req,
  output logic sel_wb,
  output logic take_cmp,
  output logic link_done,
  output logic wb_done
);
  dql_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       idle, start_wb, fire;

  assign idle      = (state_q == ST_IDLE);
  assign start_wb  = idle && pend_q;
  assign cmp_ready = idle && !pend_q;
  assign take_cmp  = cmp_ready && cmp_valid;
  assign mem_req   = !idle;
  assign sel_wb    = (state_q == ST_WB);
  assign fire      = mem_req && mem_ack;
  assign link_done = fire && (state_q == ST_LINK);
  assign wb_done   = fire && (state_q == ST_WB);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_wb)      state_d = ST_WB;
        else if (take_cmp) state_d = ST_LINK;
      end
      ST_LINK: if (mem_ack) state_d = ST_IDLE;
      ST_WB:   if (mem_ack) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // a fresh command always wins over consumption of the pending one
  assign pend_d = (pend_q && !start_wb) || wb_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/dql_head_reg.sv
module dql_head_reg #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_cmp,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic              link_done,
  input  logic              wb_done,
  output logic [ADDR_W-1:0] head,
  output logic [ADDR_W-1:0] cap_addr
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ALIGN_BITS) - 64'd1);

  logic [ADDR_W-1:0] head_q, cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cap_q  <= '0;
    end else begin
      if (take_cmp)       cap_q  <= cmp_addr & ~LOW_MASK;
      if (link_done)      head_q <= cap_q;
      else if (wb_done)   head_q <= '0;
    end
  end

  assign head     = head_q;
  assign cap_addr = cap_q;
endmodule

// File: rtl/dql_irq_flag.sv
module dql_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/done_queue_linker.sv
module done_queue_linker #(
  parameter int                   ADDR_W     = 32,
  parameter int                   ALIGN_BITS = 4,
  parameter int                   NEXT_OFS   = 8,
  parameter logic [ADDR_W-1:0]    WB_ADDR    = 32'h0000_0F84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic              wb_cmd,
  output logic              mem_req,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] head,
  output logic              irq_wb_done,
  input  logic              irq_clr
);
  localparam logic [ADDR_W-1:0] OFS_V = ADDR_W'(NEXT_OFS);

  logic              sel_wb, take_cmp, link_done, wb_done;
  logic [ADDR_W-1:0] cap_addr;

  dql_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .wb_cmd    (wb_cmd),
    .mem_ack   (mem_ack),
    .cmp_ready (cmp_ready),
    .mem_req   (mem_req),
    .sel_wb    (sel_wb),
    .take_cmp  (take_cmp),
    .link_done (link_done),
    .wb_done   (wb_done)
  );

  dql_head_reg #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_head (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_cmp  (take_cmp),
    .cmp_addr  (cmp_addr),
    .link_done (link_done),
    .wb_done   (wb_done),
    .head      (head),
    .cap_addr  (cap_addr)
  );

  dql_irq_flag u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wb_done),
    .clr   (irq_clr),
    .flag  (irq_wb_done)
  );

  assign mem_addr  = sel_wb ? WB_ADDR : (cap_addr + OFS_V);
  assign mem_wdata = head;
endmodule

// File: rtl/dql_checker.sv
module dql_checker #(
  parameter int                ADDR_W   = 32,
  parameter int                NEXT_OFS = 8,
  parameter logic [ADDR_W-1:0] WB_ADDR  = 32'h0000_0F84
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_ready,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] head,
  input logic              irq_wb_done,
  input logic              irq_clr,
  input logic              is_wb
);
  localparam logic [ADDR_W-1:0] OFS_V = ADDR_W'(NEXT_OFS);

  AST_HEAD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    head[3:0] == 4'h0); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)); // R3
  AST_LINK_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !is_wb |=> head == $past(mem_addr) - OFS_V); // R4
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cmp_ready); // R5
  AST_WB_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && is_wb |-> mem_addr == WB_ADDR); // R6
  AST_WB_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && is_wb |=> head == '0 && irq_wb_done); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wb_done && !irq_clr |=> irq_wb_done); // R8
  AST_HEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_ack) |=> $stable(head)); // R9

  logic unused_data;
  assign unused_data = ^mem_wdata;
endmodule

bind done_queue_linker dql_checker #(
  .ADDR_W   (ADDR_W),
  .NEXT_OFS (NEXT_OFS),
  .WB_ADDR  (WB_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_ready   (cmp_ready),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .head        (head),
  .irq_wb_done (irq_wb_done),
  .irq_clr     (irq_clr),
  .is_wb       (sel_wb)
);

// File: tb/tb_done_queue_linker.sv
module tb_done_queue_linker;
  localparam logic [31:0] WBA = 32'h0000_0F84;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmp_valid = 1'b0, cmp_ready, wb_cmd = 1'b0, mem_req, mem_ack = 1'b0, irq_wb_done, irq_clr = 1'b0;
  logic [31:0] cmp_addr = '0, mem_addr, mem_wdata, head;

  done_queue_linker #(.ADDR_W(32), .ALIGN_BITS(4), .NEXT_OFS(8), .WB_ADDR(WBA)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_addr(cmp_addr),
    .wb_cmd(wb_cmd), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .head(head), .irq_wb_done(irq_wb_done), .irq_clr(irq_clr));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int ack_delay = 0, req_age = 0;
  logic [31:0] cq[$];
  logic [31:0] wl_a[$], wl_d[$];

  // behavioural reference: 0 idle, 1 link write, 2 writeback write
  int          m_st = 0;
  bit          m_pend = 0, m_irq = 0;
  logic [31:0] m_head = '0, m_cap = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pend = 0; m_irq = 0; m_head = '0; m_cap = '0; req_age = 0;
    end else begin
      bit acc, wbs, ack_now;
      acc     = cmp_valid && m_st == 0 && !m_pend;
      wbs     = m_st == 0 && m_pend;
      ack_now = m_st != 0 && mem_ack;
      if (mem_req && mem_ack) begin wl_a.push_back(mem_addr); wl_d.push_back(mem_wdata); end
      if (ack_now && m_st == 2) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (m_st == 1 && ack_now) begin m_head = m_cap; m_st = 0; end
      else if (m_st == 2 && ack_now) begin m_head = '0; m_st = 0; end
      else if (wbs) m_st = 2;
      else if (acc) begin m_cap = cmp_addr & 32'hFFFF_FFF0; m_st = 1; void'(cq.pop_front()); end
      m_pend = (m_pend && !wbs) || wb_cmd;
      req_age = (mem_req && !mem_ack) ? req_age + 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(cmp_ready == (m_st == 0 && !m_pend), "R5 cmp_ready", 32'(cmp_ready), 32'(m_st == 0 && !m_pend));
      check(mem_req == (m_st != 0), "R3 mem_req", 32'(mem_req), 32'(m_st != 0));
      if (m_st == 1) begin
        check(mem_addr == m_cap + 32'd8, "R3 link addr", mem_addr, m_cap + 32'd8);
        check(mem_wdata == m_head, "R3 link data", mem_wdata, m_head);
      end
      if (m_st == 2) begin
        check(mem_addr == WBA, "R6 wb addr", mem_addr, WBA);
        check(mem_wdata == m_head, "R6 wb data", mem_wdata, m_head);
      end
      check(head == m_head, "R4 R9 head", head, m_head);
      check(head[3:0] == 4'h0, "R2 head align", head, m_head);
      check(irq_wb_done == m_irq, "R8 irq", 32'(irq_wb_done), 32'(m_irq));
    end
    cmp_valid = rst_n && cq.size() > 0;
    cmp_addr  = (cq.size() > 0) ? cq[0] : 32'h0;
    mem_ack   = mem_req && (req_age >= ack_delay);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic pulse_wb();
    @(negedge clk); wb_cmd = 1'b1; @(negedge clk); wb_cmd = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (cq.size() > 0 || m_st != 0 || m_pend || wb_cmd);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(head == 0, "R1 reset head", head, 0);
    check(irq_wb_done == 0, "R1 reset irq", 32'(irq_wb_done), 0);
    check(mem_req == 0, "R1 reset req", 32'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmp_ready == 1, "R1 reset ready", 32'(cmp_ready), 1);

    // immediate acknowledge, unaligned low bits
    ack_delay = 0;
    cq.push_back(32'h1000_0003); cq.push_back(32'h2000_0010); cq.push_back(32'h3000_00FF);
    wait_idle();
    check(head == 32'h3000_00F0, "R2 R4 head after chain", head, 32'h3000_00F0);
    check(wl_a.size() == 3 && wl_a[1] == 32'h2000_0018 && wl_d[1] == 32'h1000_0000,
          "R3 second link write", wl_d[1], 32'h1000_0000);

    // slow acknowledge, completions held under back-pressure
    ack_delay = 3;
    for (int i = 0; i < 4; i++) cq.push_back(32'h4000_0000 + 32'(i * 32'h40 + i));
    wait_idle();
    check(head == 32'h4000_00C0, "R5 no completion dropped", head, 32'h4000_00C0);
    check(wl_a.size() == 7 && wl_d[6] == 32'h4000_0080, "R5 chain order", wl_d[6], 32'h4000_0080);

    // writeback while idle, status stays set
    pulse_wb();
    wait_idle();
    check(head == 0, "R6 head cleared", head, 0);
    check(irq_wb_done == 1, "R6 irq set", 32'(irq_wb_done), 1);
    check(wl_a[7] == WBA && wl_d[7] == 32'h4000_00C0, "R6 wb write", wl_d[7], 32'h4000_00C0);
    repeat (5) @(negedge clk);
    check(irq_wb_done == 1, "R8 irq sticky", 32'(irq_wb_done), 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check(irq_wb_done == 0, "R8 irq cleared", 32'(irq_wb_done), 0);

    // writeback during link, plus a completion waiting behind it
    ack_delay = 4;
    cq.push_back(32'h5000_0100);
    do @(negedge clk); while (m_st != 1);
    wb_cmd = 1'b1; cq.push_back(32'h6000_0200);
    @(negedge clk); wb_cmd = 1'b0;
    wait_idle();
    check(wl_a[8] == 32'h5000_0108, "R7 link first", wl_a[8], 32'h5000_0108);
    check(wl_a[9] == WBA && wl_d[9] == 32'h5000_0100, "R7 wb deferred", wl_d[9], 32'h5000_0100);
    check(wl_a[10] == 32'h6000_0208 && wl_d[10] == 0, "R7 completion after wb", wl_d[10], 0);
    check(head == 32'h6000_0200, "R4 head after defer", head, 32'h6000_0200);

    // clear held across the writeback acknowledge: set wins
    ack_delay = 2;
    pulse_wb();
    do @(negedge clk); while (!(m_st == 2 && req_age >= ack_delay));
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check(irq_wb_done == 1, "R8 set wins over clear", 32'(irq_wb_done), 1);
    wait_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule